// File: doc/BRIEF.md
# Flash ISP Command Controller

This block sits between a register bus and an on-chip, word-addressed flash array and runs in-system programming commands on software's behalf. Software places a byte address, a data word and a 6-bit command code in ordinary registers, then sets a start bit. The controller checks the request against the region being touched, the update permissions and the system hazard inputs. It then either issues one request to the flash backend or rejects the command. The start bit drops by itself when the work ends, and a sticky fail flag records a rejection.

The control bits and the start bit are guarded. They can only be written after a three-byte unlock sequence has been written to a protection register. A vector-remap command and two identification reads complete inside the controller and never reach the flash. Brown-out, debugger presence, security lock and the area the processor executes from arrive as plain inputs.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset every register reads 0, except that control bit 1 (boot select) reads the inverse of `cfg_boot[1]`. Status bits 2:1 always show `cfg_boot`, and the protection register at offset 0x20 reads 0 (locked).
- R2: Writing 0x59, 0x16 and 0x88 in that order to offset 0x20 unlocks the protection gate, and bit 0 of that register then reads 1. A wrong byte restarts the sequence, and 0x59 counts as a fresh first byte. Writing 0 while unlocked locks the gate again.
- R3: While the gate is locked, writes to the control register (offset 0x00), the trigger (offset 0x10) and fail-flag clears have no effect.
- R4: A write of 1 to trigger bit 0 is ignored while control bit 0 (enable) is 0.
- R5: A trigger write starts an operation, and trigger bit 0 and status (offset 0x40) bit 0 both read 1. A flash operation raises `fl_req` for exactly one cycle. The start bit clears on the cycle after `fl_done`.
- R6: Command 0x21 programs the word in the data register (offset 0x08) at the byte address in offset 0x04, using `fl_op` = 1.
- R7: Command 0x00 reads the flash with `fl_op` = 0. The returned word appears in the data register once the operation finishes.
- R8: Commands 0x04 and 0x0B load the unique-ID and company-ID parameters into the data register without any flash request.
- R9: An invalid command code, an address with bits 1:0 not 00, or an address outside the main, loader and configuration regions sets the fail flag (control bit 6). Such a command issues no flash request and keeps the start bit high for one cycle only.
- R10: Program or erase fails in three cases. The first is a main-area target below the data-flash base while executing from main with control bit 3 at 0. The second is a loader-area target while executing from the loader with control bit 5 at 0. The third is a configuration target with control bit 4 at 0. The data-flash part of the main area is exempt from the first case.
- R11: Program (0x21) or page erase (0x22, `fl_op` = 2) fails during brown-out. Page erase also fails while lock mode and a debugger are both present. Reads are unaffected.
- R12: The fail flag is visible as both control bit 6 and status bit 6. Writing 1 to bit 6 of either register, while unlocked, clears it.
- R13: Command 0x2E on a legal main or loader address loads address bits 20:9 into status bits 20:9 without a flash request.
- R14: Offset 0x14 returns the data-flash base parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| cfg_boot | input | 2 | Boot configuration field from the configuration words |
| run_in_loader | input | 1 | Processor is executing from the loader area |
| lock_mode | input | 1 | Security lock is active |
| dbg_attached | input | 1 | Debugger is connected |
| brownout | input | 1 | Brown-out condition detected |
| fl_req | output | 1 | One-cycle flash operation request |
| fl_op | output | 2 | Flash operation: 0 read, 1 program, 2 page erase |
| fl_addr | output | 32 | Flash byte address |
| fl_wdata | output | 32 | Flash program data |
| fl_rdata | input | 32 | Flash read data, valid with fl_done |
| fl_done | input | 1 | Flash operation complete |

## Verification
Some behaviours are checked on every cycle by assertions. These are: the one-cycle width of `fl_req`, the start bit dropping after `fl_done`, and the start bit never rising while the enable is 0. They also cover the control bits holding steady while locked, no program or erase request during brown-out, and a rising fail flag never paired with a request. Other behaviours only the directed scenarios can show. These are the unlock byte ordering and its restart, the values landing in the data register and the model's memory, and the region and permission matrix. The scenarios also cover the identification constants, the remap field, and clearing the fail flag through either of its two addresses.

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl #(
  parameter logic [31:0] MAIN_BASE  = 32'h0000_0000,
  parameter logic [31:0] MAIN_BYTES = 32'h0002_0000,
  parameter logic [31:0] DF_BASE    = 32'h0001_F000,
  parameter logic [31:0] LDR_BASE   = 32'h0010_0000,
  parameter logic [31:0] LDR_BYTES  = 32'h0000_1000,
  parameter logic [31:0] CFG_BASE   = 32'h0030_0000,
  parameter logic [31:0] CFG_BYTES  = 32'h0000_0008,
  parameter logic [31:0] UNIQUE_ID  = 32'h1D2C_3B4A,
  parameter logic [31:0] VENDOR_ID  = 32'h0000_00DA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  cfg_boot,
  input  logic        run_in_loader,
  input  logic        lock_mode,
  input  logic        dbg_attached,
  input  logic        brownout,
  output logic        fl_req,
  output logic [1:0]  fl_op,
  output logic [31:0] fl_addr,
  output logic [31:0] fl_wdata,
  input  logic [31:0] fl_rdata,
  input  logic        fl_done
);
  localparam logic [6:0] A_CTL = 7'h00, A_ADR = 7'h04, A_DAT = 7'h08, A_CMD = 7'h0C;
  localparam logic [6:0] A_TRG = 7'h10, A_DFB = 7'h14, A_KEY = 7'h20, A_STA = 7'h40;
  localparam logic [5:0] C_RD = 6'h00, C_UID = 6'h04, C_VID = 6'h0B;
  localparam logic [5:0] C_PG = 6'h21, C_ER = 6'h22, C_VM = 6'h2E;
  localparam logic [31:0] MAIN_END = MAIN_BASE + MAIN_BYTES;
  localparam logic [31:0] LDR_END  = LDR_BASE + LDR_BYTES;
  localparam logic [31:0] CFG_END  = CFG_BASE + CFG_BYTES;

  logic [1:0]  key_q;
  logic        en_q, bs_q, mupd_q, cupd_q, lupd_q, fail_q, go_q, wait_q, wrd_q;
  logic [31:0] adr_q, dat_q;
  logic [5:0]  cmd_q;
  logic [11:0] vmap_q;

  wire open_g = key_q == 2'd3;
  wire wr_ctl = bus_wr && bus_addr == A_CTL;
  wire wr_sta = bus_wr && bus_addr == A_STA;
  wire wr_trg = bus_wr && bus_addr == A_TRG;
  wire wr_key = bus_wr && bus_addr == A_KEY;

  wire is_rd = cmd_q == C_RD;
  wire is_uid = cmd_q == C_UID;
  wire is_vid = cmd_q == C_VID;
  wire is_pg = cmd_q == C_PG;
  wire is_er = cmd_q == C_ER;
  wire is_vm = cmd_q == C_VM;
  wire valid = is_rd | is_uid | is_vid | is_pg | is_er | is_vm;
  wire modify = is_pg | is_er;
  wire to_flash = is_rd | modify;

  wire in_main = adr_q >= MAIN_BASE && adr_q < MAIN_END;
  wire in_df   = in_main && adr_q >= DF_BASE;
  wire in_ldr  = adr_q >= LDR_BASE && adr_q < LDR_END;
  wire in_cfg  = adr_q >= CFG_BASE && adr_q < CFG_END;

  wire bad_addr = (to_flash | is_vm) &&
                  ((|adr_q[1:0]) || !(in_main || in_ldr || in_cfg) || (is_vm && in_cfg));
  wire denied = (modify && ((in_main && !in_df && !run_in_loader && !mupd_q) ||
                            (in_ldr && run_in_loader && !lupd_q) ||
                            (in_cfg && !cupd_q) || brownout)) ||
                (is_er && lock_mode && dbg_attached);
  wire reject = !valid || bad_addr || denied;
  wire launch = go_q && !wait_q;

  assign fl_req   = launch && !reject && to_flash;
  assign fl_op    = is_pg ? 2'd1 : is_er ? 2'd2 : 2'd0;
  assign fl_addr  = adr_q;
  assign fl_wdata = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= 2'd0;
      en_q <= 1'b0; bs_q <= ~cfg_boot[1]; mupd_q <= 1'b0; cupd_q <= 1'b0; lupd_q <= 1'b0;
      fail_q <= 1'b0; go_q <= 1'b0; wait_q <= 1'b0; wrd_q <= 1'b0;
      adr_q <= '0; dat_q <= '0; cmd_q <= '0; vmap_q <= '0;
    end else begin
      if (wr_key) begin
        if (open_g) begin
          if (bus_wdata == 32'd0) key_q <= 2'd0;
        end else if (key_q == 2'd1 && bus_wdata[7:0] == 8'h16) key_q <= 2'd2;
        else if (key_q == 2'd2 && bus_wdata[7:0] == 8'h88) key_q <= 2'd3;
        else key_q <= (bus_wdata[7:0] == 8'h59) ? 2'd1 : 2'd0;
      end

      if (wr_ctl && open_g) begin
        en_q <= bus_wdata[0]; bs_q <= bus_wdata[1]; mupd_q <= bus_wdata[3];
        cupd_q <= bus_wdata[4]; lupd_q <= bus_wdata[5];
      end

      if (launch && reject) fail_q <= 1'b1;
      else if (open_g && (wr_ctl || wr_sta) && bus_wdata[6]) fail_q <= 1'b0;

      if (bus_wr && bus_addr == A_ADR) adr_q <= bus_wdata;
      if (bus_wr && bus_addr == A_CMD) cmd_q <= bus_wdata[5:0];

      if (wait_q && fl_done && wrd_q) dat_q <= fl_rdata;
      else if (launch && !reject && is_uid) dat_q <= UNIQUE_ID;
      else if (launch && !reject && is_vid) dat_q <= VENDOR_ID;
      else if (bus_wr && bus_addr == A_DAT) dat_q <= bus_wdata;

      if (launch && !reject && is_vm) vmap_q <= adr_q[20:9];

      if (launch) begin
        if (reject || !to_flash) go_q <= 1'b0;
        else begin
          wait_q <= 1'b1;
          wrd_q  <= is_rd;
        end
      end else if (wait_q) begin
        if (fl_done) begin
          go_q <= 1'b0; wait_q <= 1'b0;
        end
      end else if (wr_trg && open_g && en_q && bus_wdata[0]) begin
        go_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {25'd0, fail_q, lupd_q, cupd_q, mupd_q, 1'b0, bs_q, en_q};
      A_ADR:   bus_rdata = adr_q;
      A_DAT:   bus_rdata = dat_q;
      A_CMD:   bus_rdata = {26'd0, cmd_q};
      A_TRG:   bus_rdata = {31'd0, go_q};
      A_DFB:   bus_rdata = DF_BASE;
      A_KEY:   bus_rdata = {31'd0, open_g};
      A_STA:   bus_rdata = {11'd0, vmap_q, 2'd0, fail_q, 3'd0, cfg_boot, go_q};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/flash_isp_ctrl_chk.sv
module flash_isp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fl_req,
  input logic [1:0] fl_op,
  input logic       fl_done,
  input logic       brownout,
  input logic       go_q,
  input logic       wait_q,
  input logic       en_q,
  input logic       fail_q,
  input logic [1:0] key_q,
  input logic [4:0] ctl_bits
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fl_req |=> !fl_req); // R5
  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n) (wait_q && fl_done) |=> !go_q); // R5
  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(go_q) |-> en_q); // R4
  AST_LOCKED_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (key_q != 2'd3) |=> $stable(ctl_bits)); // R3
  AST_NO_MODIFY_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n) (fl_req && fl_op != 2'd0) |-> !brownout); // R11
  AST_FAIL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail_q) |-> $past(!fl_req)); // R9
endmodule

bind flash_isp_ctrl flash_isp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fl_req(fl_req), .fl_op(fl_op), .fl_done(fl_done),
  .brownout(brownout), .go_q(go_q), .wait_q(wait_q), .en_q(en_q), .fail_q(fail_q),
  .key_q(key_q), .ctl_bits({lupd_q, cupd_q, mupd_q, bs_q, en_q})
);

// File: tb/flash_isp_ctrl_test.sv
module flash_isp_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] UID = 32'h1D2C_3B4A;
  localparam logic [31:0] VID = 32'h0000_00DA;
  localparam logic [31:0] DFB = 32'h0001_F000;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] cfg_boot = 2'b10;
  logic run_in_loader = 0, lock_mode = 0, dbg_attached = 0, brownout = 0;
  logic fl_req, fl_done = 0;
  logic [1:0] fl_op;
  logic [31:0] fl_addr, fl_wdata, fl_rdata = 0;

  int checks = 0, fails = 0, req_cnt = 0, cycles = 0;
  bit ended = 0;

  flash_isp_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [int unsigned];
  int cnt = 0;
  logic [1:0] m_op;
  logic [31:0] m_addr, m_data;

  always @(posedge clk) begin
    fl_done <= 0;
    if (fl_req) begin
      req_cnt <= req_cnt + 1;
      cnt <= 3; m_op <= fl_op; m_addr <= fl_addr; m_data <= fl_wdata;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        fl_done <= 1;
        if (m_op == 2'd0) fl_rdata <= mem.exists(m_addr) ? mem[m_addr] : 32'hFFFF_FFFF;
        else if (m_op == 2'd1) mem[m_addr] = m_data;
        else for (int i = 0; i < 128; i++) mem[(m_addr & ~32'h1FF) + 4*i] = 32'hFFFF_FFFF;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [6:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v); chk(v == exp, req, v, exp);
  endtask

  task automatic unlock();
    wr(7'h20, 32'h59); wr(7'h20, 32'h16); wr(7'h20, 32'h88);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(7'h40, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    chk(0, "R5 start bit never cleared", 1, 0);
  endtask

  task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input logic [31:0] d,
                         input bit exp_fail, input int exp_reqs, input string req);
    logic [31:0] v;
    int r0;
    wr(7'h0C, {26'd0, c}); wr(7'h04, a); wr(7'h08, d);
    r0 = req_cnt;
    wr(7'h10, 32'h1);
    wait_idle();
    rd(7'h40, v);
    chk(v[6] == exp_fail, req, {31'd0, v[6]}, {31'd0, exp_fail});
    chk(req_cnt - r0 == exp_reqs, req, req_cnt - r0, exp_reqs);
    if (v[6]) wr(7'h40, 32'h40);
  endtask

  task automatic t_reset();
    expect_reg(7'h00, 32'h0, "R1 control after reset");
    expect_reg(7'h10, 32'h0, "R1 trigger after reset");
    expect_reg(7'h40, 32'h4, "R1 status shows cfg_boot");
    expect_reg(7'h20, 32'h0, "R1 gate locked");
    expect_reg(7'h08, 32'h0, "R1 data after reset");
  endtask

  task automatic t_lock();
    wr(7'h00, 32'h3B);
    expect_reg(7'h00, 32'h0, "R3 locked control write ignored");
    wr(7'h20, 32'h59); wr(7'h20, 32'h16); wr(7'h20, 32'h77); wr(7'h20, 32'h88);
    expect_reg(7'h20, 32'h0, "R2 broken sequence stays locked");
    wr(7'h20, 32'h59); wr(7'h20, 32'h59); wr(7'h20, 32'h16); wr(7'h20, 32'h88);
    expect_reg(7'h20, 32'h1, "R2 0x59 restarts sequence");
    wr(7'h20, 32'h0);
    expect_reg(7'h20, 32'h0, "R2 zero relocks");
    unlock();
    expect_reg(7'h20, 32'h1, "R2 unlocked");
  endtask

  task automatic t_en_off();
    int r0 = req_cnt;
    wr(7'h0C, 32'h0); wr(7'h04, 32'h100);
    wr(7'h10, 32'h1);
    expect_reg(7'h10, 32'h0, "R4 trigger ignored when disabled");
    repeat (6) @(negedge clk);
    chk(req_cnt == r0, "R4 no flash request", req_cnt - r0, 0);
    wr(7'h00, 32'h09);
    expect_reg(7'h00, 32'h09, "R3 unlocked control write");
  endtask

  task automatic t_program_read();
    logic [31:0] v;
    wr(7'h0C, 32'h21); wr(7'h04, 32'h100); wr(7'h08, 32'hCAFE_0001);
    wr(7'h10, 32'h1);
    rd(7'h10, v); chk(v == 1, "R5 trigger reads busy", v, 1);
    rd(7'h40, v); chk(v[0] == 1, "R5 status mirrors busy", v, 1);
    wait_idle();
    expect_reg(7'h10, 32'h0, "R5 trigger self-clears");
    v = mem.exists(32'h100) ? mem[32'h100] : 32'hX;
    chk(v == 32'hCAFE_0001, "R6 word programmed", v, 32'hCAFE_0001);
    run_cmd(6'h00, 32'h100, 32'h0, 0, 1, "R7 read runs");
    expect_reg(7'h08, 32'hCAFE_0001, "R7 read data returned");
  endtask

  task automatic t_ids();
    run_cmd(6'h04, 32'h0, 32'h0, 0, 0, "R8 unique id no flash");
    expect_reg(7'h08, UID, "R8 unique id value");
    run_cmd(6'h0B, 32'h0, 32'h0, 0, 0, "R8 company id no flash");
    expect_reg(7'h08, VID, "R8 company id value");
  endtask

  task automatic t_reject();
    logic [31:0] v;
    int r0;
    wr(7'h0C, 32'h3F);
    r0 = req_cnt;
    wr(7'h10, 32'h1);
    rd(7'h10, v); chk(v == 1, "R9 busy for one cycle", v, 1);
    @(negedge clk);
    rd(7'h10, v); chk(v == 0, "R9 rejected finishes next cycle", v, 0);
    chk(req_cnt == r0, "R9 no request on invalid", req_cnt - r0, 0);
    expect_reg(7'h00, 32'h49, "R12 fail in control bit 6");
    rd(7'h40, v); chk(v[6] == 1, "R12 fail in status bit 6", v, 32'h40);
    wr(7'h40, 32'h40);
    expect_reg(7'h00, 32'h09, "R12 cleared through status");
    wr(7'h10, 32'h1); wait_idle();
    wr(7'h00, 32'h49);
    rd(7'h40, v); chk(v[6] == 0, "R12 cleared through control", v, 0);
    run_cmd(6'h00, 32'h102, 32'h0, 1, 0, "R9 misaligned address");
    run_cmd(6'h00, 32'h0005_0000, 32'h0, 1, 0, "R9 out of range address");
  endtask

  task automatic t_perm();
    wr(7'h00, 32'h03);
    run_cmd(6'h21, 32'h200, 32'h5, 1, 0, "R10 main self-write blocked");
    run_cmd(6'h21, 32'h0001_F000, 32'h6, 0, 1, "R10 data flash exempt");
    run_in_loader = 1;
    run_cmd(6'h21, 32'h200, 32'h7, 0, 1, "R10 main writable from loader");
    run_cmd(6'h21, 32'h0010_0000, 32'h8, 1, 0, "R10 loader self-write blocked");
    run_cmd(6'h00, 32'h0010_0000, 32'h0, 0, 1, "R10 loader read allowed");
    wr(7'h00, 32'h23);
    run_cmd(6'h21, 32'h0010_0000, 32'h8, 0, 1, "R10 loader write enabled");
    run_cmd(6'h21, 32'h0030_0000, 32'h9, 1, 0, "R10 config blocked");
    wr(7'h00, 32'h13);
    run_cmd(6'h21, 32'h0030_0000, 32'h9, 0, 1, "R10 config enabled");
    run_in_loader = 0;
    wr(7'h00, 32'h09);
  endtask

  task automatic t_hazard();
    logic [31:0] v;
    brownout = 1;
    run_cmd(6'h21, 32'h0001_F004, 32'h1, 1, 0, "R11 program in brownout");
    run_cmd(6'h22, 32'h0001_F000, 32'h0, 1, 0, "R11 erase in brownout");
    run_cmd(6'h00, 32'h0001_F000, 32'h0, 0, 1, "R11 read in brownout");
    brownout = 0; lock_mode = 1; dbg_attached = 1;
    run_cmd(6'h22, 32'h0001_F000, 32'h0, 1, 0, "R11 erase locked with debugger");
    run_cmd(6'h21, 32'h0001_F004, 32'h1, 0, 1, "R11 program locked with debugger");
    lock_mode = 0;
    run_cmd(6'h22, 32'h0001_F000, 32'h0, 0, 1, "R11 erase with debugger only");
    v = mem[32'h0001_F004];
    chk(v == 32'hFFFF_FFFF, "R11 erase reached flash", v, 32'hFFFF_FFFF);
    dbg_attached = 0;
  endtask

  task automatic t_remap();
    logic [31:0] v;
    run_cmd(6'h2E, 32'h0000_1200, 32'h0, 0, 0, "R13 remap no flash");
    rd(7'h40, v); chk(v[20:9] == 12'd9, "R13 remap field", {20'd0, v[20:9]}, 9);
    run_cmd(6'h2E, 32'h0030_0000, 32'h0, 1, 0, "R13 remap on config rejected");
  endtask

  task automatic t_dfbase();
    expect_reg(7'h14, DFB, "R14 data flash base");
    wr(7'h14, 32'h1234);
    expect_reg(7'h14, DFB, "R14 base write ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_lock(); t_en_off(); t_program_read(); t_ids();
    t_reject(); t_perm(); t_hazard(); t_remap(); t_dfbase();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule